// File: doc/BRIEF.md
# Eight-Level Polled Interrupt Controller

This block gathers eight interrupt request lines and picks one to service. It latches a rising edge on each line into a request register, holds a per-line mask, and resolves a fixed priority in which line 0 is the most urgent. It keeps an in-service register of the levels being handled, and it raises its interrupt output whenever a request could preempt the work already in service.

A host reaches the block through two byte addresses selected by one address bit. Address 0 takes commands and address 1 takes data. There is no vectored acknowledge cycle. Instead, the host arms a poll and then reads address 0. That read returns the winning level and acknowledges it. The host can also choose whether address 0 reads show the request register or the in-service register, which lets software spot a level-7 report that has nothing in service behind it.

A start command opens an initialization sequence of up to three data words: a vector base, a cascade word and a mode word. The cascade word is a slave-attachment bitmask on a master and an identity number on a slave. The three words are presented on configuration outputs for neighbouring logic to use.

Top module: `pic8_core`

## Requirements
- R1: After reset the mask is 0xFF and the request and in-service registers are 0. Address 0 reads show the request register, irq_out is low and all three configuration outputs are 0x00.
- R2: A 0-to-1 change on req_in[k] between two clock edges sets request bit k. The bit stays set until level k is acknowledged by a poll. A line that stays high after its acknowledgement does not set the bit again.
- R3: Outside initialization, a write to address 1 loads the mask, where bit k = 1 masks line k. A read of address 1 returns the mask. A masked request neither raises irq_out nor wins a poll.
- R4: irq_out is high exactly when some unmasked request bit has a lower index than every set in-service bit. An empty in-service register counts as index 8.
- R5: A command byte with bits 4 and 3 clear and bits 7:5 = 001 (for example 0x20) clears the lowest-index set bit of the in-service register. When the in-service register is empty it has no effect.
- R6: A command byte with bit 4 clear and bits 3 and 2 set (for example 0x0C) arms a poll. The next read of address 0 returns 0x80 | level for the winning level. That read sets the level's in-service bit and clears its request bit, and the poll is then disarmed.
- R7: A poll read with no winning level returns 0x07 and leaves both the in-service and request registers unchanged.
- R8: A command byte with bit 4 clear, bit 3 set and bit 1 set chooses what later address-0 reads show: the in-service register when bit 0 = 1 (0x0B), the request register when bit 0 = 0 (0x0A). The choice persists.
- R9: A command byte with bit 4 set starts initialization. It clears the request, in-service and mask registers, selects the request register for address-0 reads and disarms any poll. The following address-1 writes fill, in order, the vector base, the cascade word (skipped when the start byte has bit 1 set) and the mode word (present only when the start byte has bit 0 set). After that, normal operation resumes. While initialization runs, data writes do not touch the mask and other command bytes are ignored.
- R10: The configuration outputs present the vector base, cascade word and mode word exactly as they were written, for both a master cascade bitmask (0x04) and a slave identity (0x02).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 8 | Interrupt request lines, edge sensed |
| bus_a0 | input | 1 | Register select: 0 = command, 1 = data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read; poll side effects happen at the end of the cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle bus_rd is high |
| irq_out | output | 1 | Interrupt request to the host |
| cfg_vec_base | output | 8 | Vector base word from initialization |
| cfg_cascade | output | 8 | Cascade word: slave bitmask on a master, identity on a slave |
| cfg_mode | output | 8 | Mode word from initialization |

## Verification
Priority is first tried with two requests pending at once behind a partial mask. The first poll must pick the lower index, and the higher-index request must not raise irq_out once the lower level is in service. A more urgent line is then raised while a level is in service, which separates true preemption from a plain test for any pending request. End-of-interrupt is then issued three times, once per set in-service bit and once on an empty register, to confirm it always clears the lowest set bit. Initialization is run with three start bytes (full, cascade skipped, mode omitted) to confirm that word ordering and the mask hand-back follow the start byte. A long random stretch of commands, reads and line changes is then compared cycle by cycle with a behavioural model.

// File: rtl/pic8_pkg.sv
`timescale 1ns/1ps
package pic8_pkg;
  localparam int NLEV = 8;
  localparam int LVW  = $clog2(NLEV);
  localparam int DW   = 8;

  typedef enum logic [1:0] {
    SEQ_RUN  = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_CASC = 2'd2,
    SEQ_MODE = 2'd3
  } seq_state_e;

  // index of the lowest set bit; NLEV when none is set
  function automatic logic [LVW:0] first_set(input logic [NLEV-1:0] v);
    logic [LVW:0] idx;
    idx = (LVW+1)'(NLEV);
    for (int i = NLEV-1; i >= 0; i--)
      if (v[i]) idx = (LVW+1)'(i);
    return idx;
  endfunction

  // isolate the lowest set bit
  function automatic logic [NLEV-1:0] lowest_bit(input logic [NLEV-1:0] v);
    return v & (~v + {{(NLEV-1){1'b0}}, 1'b1});
  endfunction

  // poll result: flag in msb, level in low bits, all-ones level when empty
  function automatic logic [DW-1:0] poll_word(input logic valid, input logic [LVW-1:0] lvl);
    logic [DW-1:0] w;
    w = '0;
    w[DW-1] = valid;
    w[LVW-1:0] = valid ? lvl : {LVW{1'b1}};
    return w;
  endfunction
endpackage

// File: rtl/pic8_req_latch.sv
`timescale 1ns/1ps
module pic8_req_latch
  import pic8_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLEV-1:0] req_in,
  input  logic            clr_all,
  input  logic [NLEV-1:0] ack_onehot,
  output logic [NLEV-1:0] irr,
  output logic [NLEV-1:0] rise
);
  logic [NLEV-1:0] prev_q;

  assign rise = req_in & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr    <= '0;
    end else begin
      prev_q <= req_in;
      if (clr_all) irr <= '0;
      else         irr <= (irr & ~ack_onehot) | rise;
    end
  end

  // R2: a fresh edge is always recorded
  a_r2_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_all |=> ((irr & $past(rise)) == $past(rise)));
endmodule

// File: rtl/pic8_prio_resolve.sv
`timescale 1ns/1ps
module pic8_prio_resolve
  import pic8_pkg::*;
(
  input  logic [NLEV-1:0] irr,
  input  logic [NLEV-1:0] mask,
  input  logic [NLEV-1:0] isr,
  output logic            win_valid,
  output logic [LVW-1:0]  win_level,
  output logic [NLEV-1:0] win_onehot
);
  logic [NLEV-1:0] pend;
  logic [LVW:0]    pend_idx;
  logic [LVW:0]    isr_idx;

  always_comb begin
    pend       = irr & ~mask;
    pend_idx   = first_set(pend);
    isr_idx    = first_set(isr);
    win_valid  = pend_idx < isr_idx;
    win_level  = pend_idx[LVW-1:0];
    win_onehot = win_valid ? lowest_bit(pend) : '0;
  end
endmodule

// File: rtl/pic8_cfg_seq.sv
`timescale 1ns/1ps
module pic8_cfg_seq
  import pic8_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_a0,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          poll_take,
  output logic [DW-1:0] mask,
  output logic          sel_isr,
  output logic          poll_armed,
  output logic          start_fire,
  output logic          eoi_fire,
  output logic [DW-1:0] vec_base,
  output logic [DW-1:0] cascade,
  output logic [DW-1:0] mode
);
  seq_state_e state;
  logic       skip_casc;
  logic       want_mode;
  logic       cmd_wr;
  logic       run;

  assign cmd_wr     = bus_wr & ~bus_a0;
  assign run        = (state == SEQ_RUN);
  assign start_fire = cmd_wr & bus_wdata[4];
  assign eoi_fire   = cmd_wr & run & ~bus_wdata[4] & ~bus_wdata[3] & (bus_wdata[7:5] == 3'b001);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= SEQ_RUN;
      mask       <= '1;
      sel_isr    <= 1'b0;
      poll_armed <= 1'b0;
      skip_casc  <= 1'b0;
      want_mode  <= 1'b0;
      vec_base   <= '0;
      cascade    <= '0;
      mode       <= '0;
    end else begin
      if (poll_take) poll_armed <= 1'b0;
      if (start_fire) begin
        state      <= SEQ_BASE;
        mask       <= '0;
        sel_isr    <= 1'b0;
        poll_armed <= 1'b0;
        skip_casc  <= bus_wdata[1];
        want_mode  <= bus_wdata[0];
      end else if (bus_wr && bus_a0) begin
        unique case (state)
          SEQ_RUN:  mask <= bus_wdata;
          SEQ_BASE: begin
            vec_base <= bus_wdata;
            state    <= skip_casc ? (want_mode ? SEQ_MODE : SEQ_RUN) : SEQ_CASC;
          end
          SEQ_CASC: begin
            cascade <= bus_wdata;
            state   <= want_mode ? SEQ_MODE : SEQ_RUN;
          end
          SEQ_MODE: begin
            mode  <= bus_wdata;
            state <= SEQ_RUN;
          end
          default: state <= SEQ_RUN;
        endcase
      end else if (cmd_wr && run && bus_wdata[3]) begin
        if (bus_wdata[2]) poll_armed <= 1'b1;
        if (bus_wdata[1]) sel_isr <= bus_wdata[0];
      end
    end
  end

  // R9: a start byte always opens the sequence with an open mask
  a_r9_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> (state == SEQ_BASE && mask == '0 && !poll_armed));
  // R6: a poll read disarms the poll unless a new arm arrives
  a_r6_poll_once: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_take && !bus_wr) |=> !poll_armed);
endmodule

// File: rtl/pic8_core.sv
`timescale 1ns/1ps
module pic8_core
  import pic8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] req_in,
  input  logic       bus_a0,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq_out,
  output logic [7:0] cfg_vec_base,
  output logic [7:0] cfg_cascade,
  output logic [7:0] cfg_mode
);
  logic [NLEV-1:0] irr, isr, mask, rise;
  logic [NLEV-1:0] win_onehot, ack_set, eoi_clr;
  logic [LVW-1:0]  win_level;
  logic            win_valid, sel_isr, poll_armed;
  logic            start_fire, eoi_fire, poll_take, poll_ack;

  assign poll_take = bus_rd & ~bus_a0 & poll_armed;
  assign poll_ack  = poll_take & win_valid;
  assign ack_set   = poll_ack ? win_onehot : '0;
  assign eoi_clr   = eoi_fire ? lowest_bit(isr) : '0;

  pic8_req_latch u_latch (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .clr_all(start_fire),
    .ack_onehot(ack_set), .irr(irr), .rise(rise)
  );

  pic8_prio_resolve u_prio (
    .irr(irr), .mask(mask), .isr(isr),
    .win_valid(win_valid), .win_level(win_level), .win_onehot(win_onehot)
  );

  pic8_cfg_seq u_seq (
    .clk(clk), .rst_n(rst_n), .bus_a0(bus_a0), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .poll_take(poll_take), .mask(mask),
    .sel_isr(sel_isr), .poll_armed(poll_armed), .start_fire(start_fire),
    .eoi_fire(eoi_fire), .vec_base(cfg_vec_base), .cascade(cfg_cascade),
    .mode(cfg_mode)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          isr <= '0;
    else if (start_fire) isr <= '0;
    else                 isr <= (isr & ~eoi_clr) | ack_set;
  end

  assign irq_out = win_valid;

  always_comb begin
    if (bus_a0)          bus_rdata = mask;
    else if (poll_armed) bus_rdata = poll_word(win_valid, win_level);
    else if (sel_isr)    bus_rdata = isr;
    else                 bus_rdata = irr;
  end

  // R6: the acknowledged level is in service afterwards
  a_r6_poll_marks_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_ack && !start_fire) |=> ((isr & $past(ack_set)) == $past(ack_set)));
  // R7: an empty poll leaves the in-service register alone
  a_r7_empty_poll_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_take && !win_valid && !eoi_fire && !start_fire) |=> (isr == $past(isr)));
  // R5: end-of-interrupt removes at most one in-service bit
  a_r5_eoi_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_fire && !poll_ack) |=>
      ($countones(isr) == $countones($past(isr)) - (($past(isr) != '0) ? 1 : 0)));
  // R4: the winner is one unmasked pending request
  a_r4_win_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> ($onehot0(win_onehot) && ((win_onehot & irr & ~mask) == win_onehot)));
  // R9: initialization empties both request and service state
  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> (isr == '0 && irr == '0));
endmodule

// File: tb/pic8_core_tb.sv
`timescale 1ns/1ps
module pic8_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_in = 8'h00;
  logic       bus_a0 = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata, cfg_vec_base, cfg_cascade, cfg_mode;
  logic       irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pic8_core u_dut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .bus_a0(bus_a0),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out), .cfg_vec_base(cfg_vec_base),
    .cfg_cascade(cfg_cascade), .cfg_mode(cfg_mode)
  );

  // behavioural model state
  logic [7:0] m_irr, m_isr, m_mask, m_prev, m_vec, m_casc, m_mode;
  bit m_sel_isr, m_poll, m_skip, m_want;
  int m_phase; // 0 normal, 1 base, 2 cascade, 3 mode

  function automatic int lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic int m_winner();
    int p, s;
    p = lowest(m_irr & ~m_mask);
    s = lowest(m_isr);
    return (p < s) ? p : -1;
  endfunction

  function automatic logic [7:0] m_rdata(input logic a0);
    int w;
    if (a0) return m_mask;
    if (m_poll) begin
      w = m_winner();
      return (w < 0) ? 8'h07 : (8'h80 | 8'(w));
    end
    return m_sel_isr ? m_isr : m_irr;
  endfunction

  task automatic model_reset();
    m_irr = 0; m_isr = 0; m_mask = 8'hFF; m_prev = 0;
    m_vec = 0; m_casc = 0; m_mode = 0;
    m_sel_isr = 0; m_poll = 0; m_skip = 0; m_want = 0; m_phase = 0;
  endtask

  task automatic model_step(input logic a0, wr, rd, input logic [7:0] wd, input logic [7:0] rq);
    logic [7:0] rise, ack;
    int w, e;
    rise = rq & ~m_prev;
    m_prev = rq;
    ack = 0;
    if (rd && !a0 && m_poll) begin
      w = m_winner();
      if (w >= 0) ack = 8'(1 << w);
      m_poll = 0;
    end
    if (wr && !a0 && wd[4]) begin
      m_irr = 0; m_isr = 0; m_mask = 0; m_sel_isr = 0; m_poll = 0;
      m_phase = 1; m_skip = wd[1]; m_want = wd[0];
      return;
    end
    m_irr = (m_irr & ~ack) | rise;
    if (wr && !a0 && m_phase == 0 && wd[4:3] == 2'b00 && wd[7:5] == 3'b001) begin
      e = lowest(m_isr);
      if (e < 8) m_isr[e] = 1'b0;
    end
    m_isr = m_isr | ack;
    if (wr && a0) begin
      case (m_phase)
        0: m_mask = wd;
        1: begin m_vec = wd; m_phase = !m_skip ? 2 : (m_want ? 3 : 0); end
        2: begin m_casc = wd; m_phase = m_want ? 3 : 0; end
        default: begin m_mode = wd; m_phase = 0; end
      endcase
    end else if (wr && !a0 && m_phase == 0 && wd[3]) begin
      if (wd[2]) m_poll = 1;
      if (wd[1]) m_sel_isr = wd[0];
    end
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", tag, got, exp, $time);
    end
  endtask

  // one bus cycle; called at a falling edge, returns at the next falling edge
  task automatic cyc(input logic a0, wr, rd, input logic [7:0] wd, output logic [7:0] seen);
    bus_a0 = a0; bus_wr = wr; bus_rd = rd; bus_wdata = wd;
    #1;
    chk("R4 irq_out vs model", {7'b0, irq_out}, {7'b0, (m_winner() >= 0)});
    if (rd) chk("R3/R6/R8 read vs model", bus_rdata, m_rdata(a0));
    seen = bus_rdata;
    @(posedge clk);
    model_step(a0, wr, rd, wd, req_in);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic wrc(input logic [7:0] d); logic [7:0] s; cyc(1'b0, 1'b1, 1'b0, d, s); endtask
  task automatic wrd(input logic [7:0] d); logic [7:0] s; cyc(1'b1, 1'b1, 1'b0, d, s); endtask
  task automatic idle(); logic [7:0] s; cyc(1'b0, 1'b0, 1'b0, 8'h00, s); endtask
  task automatic rd_exp(input logic a0, input logic [7:0] exp, input string tag);
    logic [7:0] s;
    cyc(a0, 1'b0, 1'b1, 8'h00, s);
    chk(tag, s, exp);
  endtask
  task automatic irq_exp(input logic exp, input string tag);
    chk(tag, {7'b0, irq_out}, {7'b0, exp});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] s;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    irq_exp(1'b0, "R1 irq after reset");
    rd_exp(1'b1, 8'hFF, "R1 mask after reset");
    rd_exp(1'b0, 8'h00, "R1 request reg after reset");
    chk("R1 cfg_vec_base", cfg_vec_base, 8'h00);
    chk("R1 cfg_cascade", cfg_cascade, 8'h00);
    chk("R1 cfg_mode", cfg_mode, 8'h00);
    // master initialization
    wrc(8'h11); wrd(8'h00); wrd(8'h04); wrd(8'h01);
    chk("R10 master cascade", cfg_cascade, 8'h04);
    chk("R10 master mode", cfg_mode, 8'h01);
    rd_exp(1'b1, 8'h00, "R9 mask open after init");
    wrd(8'hFF);
    rd_exp(1'b1, 8'hFF, "R3 mask readback");
    // two requests behind a full mask
    req_in = 8'h28; idle();
    rd_exp(1'b0, 8'h28, "R2 edges latched");
    irq_exp(1'b0, "R3 masked requests silent");
    wrd(8'hD7);
    irq_exp(1'b1, "R4 unmasked request raises irq");
    wrc(8'h0C);
    rd_exp(1'b0, 8'h83, "R6 poll picks level 3");
    rd_exp(1'b0, 8'h20, "R6 poll disarmed, request 3 cleared");
    wrc(8'h0B);
    rd_exp(1'b0, 8'h08, "R8 in-service readback");
    irq_exp(1'b0, "R4 level 5 below in-service 3");
    // more urgent line preempts
    req_in = 8'h2A; idle();
    wrd(8'hD5);
    irq_exp(1'b1, "R4 level 1 preempts 3");
    wrc(8'h0C);
    rd_exp(1'b0, 8'h81, "R6 poll picks level 1");
    rd_exp(1'b0, 8'h0A, "R8 two levels in service");
    wrc(8'h20);
    rd_exp(1'b0, 8'h08, "R5 eoi clears level 1");
    wrc(8'h20);
    rd_exp(1'b0, 8'h00, "R5 eoi clears level 3");
    wrc(8'h20);
    rd_exp(1'b0, 8'h00, "R5 eoi on empty register");
    irq_exp(1'b1, "R4 level 5 now eligible");
    wrd(8'hFF);
    irq_exp(1'b0, "R3 mask removes irq");
    wrc(8'h0C);
    rd_exp(1'b0, 8'h07, "R7 empty poll result");
    rd_exp(1'b0, 8'h00, "R7 in-service unchanged");
    wrc(8'h0A);
    rd_exp(1'b0, 8'h20, "R7/R8 request reg unchanged, R2 held line not re-latched");
    // slave initialization
    wrc(8'h11);
    rd_exp(1'b1, 8'h00, "R9 mask cleared by start");
    wrd(8'h08); wrd(8'h02); wrd(8'h01);
    rd_exp(1'b1, 8'h00, "R9 init words not in mask");
    chk("R10 slave vector base", cfg_vec_base, 8'h08);
    chk("R10 slave identity", cfg_cascade, 8'h02);
    rd_exp(1'b0, 8'h00, "R9 request reg cleared");
    // start without cascade word; command ignored mid-sequence
    wrc(8'h13); wrc(8'h0B); wrd(8'h40); wrd(8'h03);
    chk("R9 vec after skip", cfg_vec_base, 8'h40);
    chk("R9 cascade kept", cfg_cascade, 8'h02);
    chk("R9 mode after skip", cfg_mode, 8'h03);
    req_in = 8'h00; idle(); req_in = 8'h01; idle();
    rd_exp(1'b0, 8'h01, "R9 select command ignored during init");
    wrd(8'h55);
    rd_exp(1'b1, 8'h55, "R9 normal after mode word");
    // start without mode word
    wrc(8'h10); wrd(8'h20); wrd(8'h04); wrd(8'h0F);
    rd_exp(1'b1, 8'h0F, "R9 mask after two words");
    chk("R9 mode untouched", cfg_mode, 8'h03);
    chk("R10 cascade 0x04", cfg_cascade, 8'h04);
    // random stretch against the model
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = $urandom_range(0, 11);
      if ($urandom_range(0, 3) == 0) req_in = 8'($urandom);
      case (op)
        0: wrc(8'h20);
        1: wrc(8'h0C);
        2: wrc(8'h0B);
        3: wrc(8'h0A);
        4: if ($urandom_range(0, 7) == 0) wrc(8'h11); else wrc(8'h0C);
        5: wrd(8'($urandom));
        6, 7: cyc(1'b0, 1'b0, 1'b1, 8'h00, s);
        8: cyc(1'b1, 1'b0, 1'b1, 8'h00, s);
        9: if ($urandom_range(0, 9) == 0) wrc(8'h13); else wrc(8'h20);
        default: idle();
      endcase
      chk("R10 cfg_cascade vs model", cfg_cascade, m_casc);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule